// File: doc/BRIEF.md
# Dual-channel simultaneous sample sequencer

This block is the digital control core of a converter running a paired-sampling mode. It watches three active-low strobes: chip-select, write and read. A write strobe loads a small control register. When the register selects the paired mode, every odd-numbered read falling edge freezes both input channels at the same system-clock edge. The two held values are then converted one after the other. The write rising edge and the release of chip-select each restart the odd/even count. Conversion is modelled as a fixed number of system-clock cycles. The count depends on the clock-source bit. At the end of the count each channel's held stimulus value comes back as its result.

Results come out only as a pair, through a two-entry queue. On an odd read edge the queue takes the finished pair, and the bus presents the first channel's word. On the following even read edge the bus presents the second channel's word. The host therefore always sees a pair sampled at the same instant. A complete transfer must contain an even number of reads. A sticky flag records a chip-select release after an odd number of reads.

The read strobe is the only consumer handshake. There is no back-pressure, because the host sets the pace by how far apart it places its read edges. A pair is only ready if the host leaves enough cycles between two odd read edges. All strobes are taken as already synchronous to the system clock.

Top module: `dual_sample_seq`

## Requirements
- R1: Holds and conversions start only when control bit 3 and control bit 2 are both 1 (the paired mode). In any other mode a read falling edge raises no hold.
- R2: While no conversion is running, the sampler follows the channel inputs. A hold captures the values present at the clock edge that sees the read falling edge.
- R3: Each odd-numbered read falling edge taken with chip-select low raises `hold` for exactly one cycle, starting in the cycle after that edge. Even-numbered edges raise no hold.
- R4: Both channels are frozen at the same edge. Changes on the channel inputs during a conversion do not alter that pair's results.
- R5: With control bit 5 = 1 (external source) a conversion takes 10 cycles, and with bit 5 = 0 (internal oscillator) it takes 12 cycles; call this count T. The pair from a hold at edge E is delivered by an odd read edge at E+T+1 or later. An odd read edge at E+T or earlier finds no finished pair, and both words of that read pair are 0.
- R6: An odd read edge presents the channel-A word of the previous finished pair. The next even read edge presents that pair's channel-B word.
- R7: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. `data_out` is 0 whenever `data_oe` is 0.
- R8: A write rising edge with chip-select low loads the control register from `wr_data` and makes the next read falling edge odd again. `int_osc_sel` equals the inverse of control bit 5 and is 1 after reset.
- R9: A rising edge of `cs_n` resets the odd/even count and empties the queue. It also drops any pending pair, so the next odd read presents 0.
- R10: A rising edge of `cs_n` after an odd number of reads sets `seq_err`, which stays 1 until reset. A release after an even number of reads leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| wr_n | input | 1 | Write strobe, active low, loads control on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| wr_data | input | 8 | Control value written on the write rising edge |
| ch_a | input | 10 | Channel A stimulus value |
| ch_b | input | 10 | Channel B stimulus value |
| data_out | output | 10 | Result word, 0 when not driven |
| data_oe | output | 1 | Bus drive enable (the tri-state control) |
| hold | output | 1 | One-cycle pulse when both channels are frozen |
| int_osc_sel | output | 1 | 1 when the internal oscillator is the clock source |
| seq_err | output | 1 | Sticky odd-read-count error |

## Verification
A wrong odd/even count shows up on the first read after a write or a chip-select release. `hold` pulses on the wrong edge, and the A and B words appear swapped on the bus one cycle after that edge. A conversion counter that is off by one changes whether a pair read exactly T or T+1 cycles after its hold arrives as data or as zeros. That boundary is therefore probed directly under both clock sources. A queue or sampler that fails to freeze or clear returns the wrong stimulus value on the next read pair, within one pair of reads.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W = 10;

  typedef struct packed {
    logic [WORD_W-1:0] b;
    logic [WORD_W-1:0] a;
  } pair_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[i] <= 1'b1;
      else        prev[i] <= lvl[i];
    end
    assign rise[i] = ~prev[i] &  lvl[i];
    assign fall[i] =  prev[i] & ~lvl[i];
  end
endmodule

// File: rtl/pair_convert.sv
module pair_convert
  import seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  logic [WORD_W-1:0] ch_a,
  input  logic [WORD_W-1:0] ch_b,
  output logic              hold,
  output pair_t             res,
  output logic              res_valid
);
  logic [CNT_W-1:0] cnt;
  pair_t            smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      hold      <= 1'b0;
      smp       <= '0;
      res       <= '0;
      res_valid <= 1'b0;
    end else if (clr) begin
      cnt       <= '0;
      hold      <= 1'b0;
      smp       <= '{b: ch_b, a: ch_a};
      res_valid <= 1'b0;
    end else if (start) begin
      smp       <= '{b: ch_b, a: ch_a};
      hold      <= 1'b1;
      cnt       <= CNT_W'(1);
      res_valid <= 1'b0;
    end else begin
      hold <= 1'b0;
      if (cnt == '0) begin
        smp <= '{b: ch_b, a: ch_a};
      end else if (cnt == len) begin
        res.b     <= smp.b;
        res_valid <= 1'b1;
        cnt       <= '0;
      end else begin
        if (cnt == (len >> 1)) res.a <= smp.a;
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !start |=> !hold); // R3

  AST_SAMPLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CNT_W'(1)) |-> $stable(smp)); // R4
endmodule

// File: rtl/pair_queue.sv
module pair_queue
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              take_b,
  input  pair_t             res,
  input  logic              res_valid,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] park_b;
  logic              park_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      park_b <= '0;
      park_v <= 1'b0;
      word   <= '0;
    end else if (clr) begin
      park_b <= '0;
      park_v <= 1'b0;
      word   <= '0;
    end else if (load) begin
      park_v <= res_valid;
      park_b <= res_valid ? res.b : '0;
      word   <= res_valid ? res.a : '0;
    end else if (take_b) begin
      word <= park_v ? park_b : '0;
    end
  end

  AST_QUEUE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!park_v && word == '0)); // R9

  AST_EMPTY_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load && !res_valid |=> (word == '0)); // R5
endmodule

// File: rtl/dual_sample_seq.sv
module dual_sample_seq
  import seq_pkg::*;
#(
  parameter int T_EXT = 10,
  parameter int T_INT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [7:0]        wr_data,
  input  logic [WORD_W-1:0] ch_a,
  input  logic [WORD_W-1:0] ch_b,
  output logic [WORD_W-1:0] data_out,
  output logic              data_oe,
  output logic              hold,
  output logic              int_osc_sel,
  output logic              seq_err
);
  localparam int T_MAX = (T_EXT > T_INT) ? T_EXT : T_INT;
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic [2:0] rise, fall;
  logic       cs_rise, wr_rise, rd_fall;
  logic       mode_hi, mode_lo, src_ext;
  logic       odd_seen;
  logic       dual, rd_ok, start, take_b, wr_load;
  logic [CNT_W-1:0] len_sel;
  pair_t      res;
  logic       res_valid;
  logic [WORD_W-1:0] word;
  logic       unused_bits;

  strobe_edge #(.N(3)) i_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({cs_n, wr_n, rd_n}),
    .rise (rise),
    .fall (fall)
  );

  assign cs_rise = rise[2];
  assign wr_rise = rise[1];
  assign rd_fall = fall[0];
  assign unused_bits = ^{rise[0], fall[2:1], wr_data[7:6], wr_data[4], wr_data[1:0]};

  assign dual    = mode_hi & mode_lo;
  assign wr_load = wr_rise & ~cs_n;
  assign rd_ok   = rd_fall & ~cs_n & dual;
  assign start   = rd_ok & ~odd_seen;
  assign take_b  = rd_ok &  odd_seen;
  assign len_sel = src_ext ? CNT_W'(T_EXT) : CNT_W'(T_INT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_hi  <= 1'b0;
      mode_lo  <= 1'b0;
      src_ext  <= 1'b0;
      odd_seen <= 1'b0;
      seq_err  <= 1'b0;
    end else if (cs_rise) begin
      odd_seen <= 1'b0;
      if (odd_seen) seq_err <= 1'b1;
    end else if (wr_load) begin
      mode_hi  <= wr_data[3];
      mode_lo  <= wr_data[2];
      src_ext  <= wr_data[5];
      odd_seen <= 1'b0;
    end else if (rd_ok) begin
      odd_seen <= ~odd_seen;
    end
  end

  pair_convert #(.CNT_W(CNT_W)) i_conv (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cs_rise),
    .start    (start),
    .len      (len_sel),
    .ch_a     (ch_a),
    .ch_b     (ch_b),
    .hold     (hold),
    .res      (res),
    .res_valid(res_valid)
  );

  pair_queue i_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cs_rise),
    .load     (start),
    .take_b   (take_b),
    .res      (res),
    .res_valid(res_valid),
    .word     (word)
  );

  assign int_osc_sel = ~src_ext;
  assign data_oe     = ~cs_n & ~rd_n;
  assign data_out    = data_oe ? word : '0;

  AST_HOLD_NEEDS_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> $past(dual)); // R1

  AST_EVEN_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    take_b |=> !hold); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err); // R10
endmodule

// File: tb/test_dual_sample_seq.sv
module test_dual_sample_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] wr_data = '0;
  logic [9:0] ch_a = '0, ch_b = '0;
  logic [9:0] data_out;
  logic       data_oe, hold, int_osc_sel, seq_err;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  logic [7:0] ctrl_m = '0;
  bit   odd_m = 0, pend = 0, err_m = 0;
  logic [9:0] pa = '0, pb = '0, qb = '0;
  int   hold_cyc = 0;

  dual_sample_seq i_dual_sample_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .wr_data(wr_data), .ch_a(ch_a), .ch_b(ch_b), .data_out(data_out),
    .data_oe(data_oe), .hold(hold), .int_osc_sel(int_osc_sel), .seq_err(seq_err)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int conv_len(logic [7:0] c);
    return c[5] ? 10 : 12;
  endfunction

  function automatic bit is_dual(logic [7:0] c);
    return c[3] & c[2];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    cs_n = 1'b0; wr_n = 1'b0; wr_data = v;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    ctrl_m = v; odd_m = 0;
    chk(int_osc_sel == ~v[5], "R8 clock source", int_osc_sel, ~v[5]);
  endtask

  task automatic rd_op(int lowc, int highc, logic [9:0] na, logic [9:0] nb);
    int  edge_c;
    bit  exp_hold, done;
    logic [9:0] exp_w;
    ch_a = na; ch_b = nb;
    rd_n = 1'b0;
    edge_c = cyc + 1;
    exp_hold = 0; exp_w = 'x;
    if (is_dual(ctrl_m)) begin
      if (!odd_m) begin
        done  = pend && (edge_c - hold_cyc >= conv_len(ctrl_m) + 1);
        exp_w = done ? pa : 10'd0;
        qb    = done ? pb : 10'd0;
        pend = 1; pa = na; pb = nb; hold_cyc = edge_c;
        exp_hold = 1; odd_m = 1;
      end else begin
        exp_w = qb; odd_m = 0;
      end
    end
    @(negedge clk);
    chk(hold == exp_hold, exp_hold ? "R3 hold on odd edge" : "R1 R3 no hold", hold, exp_hold);
    chk(data_oe == 1'b1, "R7 bus enabled", data_oe, 1);
    if (!$isunknown(exp_w))
      chk(data_out == exp_w, odd_m ? "R6 R2 R4 R5 word A" : "R6 R4 R5 word B", data_out, exp_w);
    for (int i = 1; i < lowc; i++) @(negedge clk);
    if (exp_hold && lowc > 1) chk(hold == 1'b0, "R3 hold one cycle", hold, 0);
    ch_a = 10'($urandom); ch_b = 10'($urandom);
    rd_n = 1'b1;
    @(negedge clk);
    chk(data_oe == 1'b0 && data_out == 10'd0, "R7 bus released", data_out, 0);
    for (int i = 1; i < highc; i++) @(negedge clk);
  endtask

  task automatic cs_release();
    cs_n = 1'b1;
    @(negedge clk);
    if (odd_m) err_m = 1;
    odd_m = 0; pend = 0; qb = '0;
    @(negedge clk);
    chk(seq_err == err_m, "R9 R10 error flag", seq_err, err_m);
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(data_oe == 0 && data_out == 0, "R7 reset bus", data_out, 0);
    chk(seq_err == 0, "R10 reset error", seq_err, 0);
    chk(int_osc_sel == 1, "R8 reset source", int_osc_sel, 1);
    chk(hold == 0, "R3 reset hold", hold, 0);

    // R7: read low with chip-select high keeps bus off
    rd_n = 1'b0;
    @(negedge clk);
    chk(data_oe == 0 && data_out == 0, "R7 cs high read", data_oe, 0);
    rd_n = 1'b1;
    @(negedge clk);

    // R1: a non-paired mode never holds
    wr_ctrl(8'h04);
    rd_op(2, 3, 10'd11, 10'd22);
    rd_op(1, 3, 10'd33, 10'd44);

    // paired mode, internal source
    wr_ctrl(8'h0C);
    rd_op(2, 1, 10'd101, 10'd202);
    rd_op(1, 14, 10'd5, 10'd6);
    rd_op(1, 1, 10'd303, 10'd404);
    rd_op(1, 14, 10'd7, 10'd8);

    // R5 boundary under both sources: spacing T then T+1
    for (int s = 0; s < 2; s++) begin
      wr_ctrl(s == 0 ? 8'h0C : 8'h2C);
      rd_op(1, 1, 10'd500 + 10'(s), 10'd600 + 10'(s));
      rd_op(1, conv_len(ctrl_m) + 1, 10'd1, 10'd2);
      rd_op(1, 1, 10'd700 + 10'(s), 10'd800 + 10'(s));
      rd_op(1, conv_len(ctrl_m) - 3, 10'd3, 10'd4);
      rd_op(1, 1, 10'd900 + 10'(s), 10'd950 + 10'(s));
      rd_op(1, conv_len(ctrl_m) - 2, 10'd9, 10'd9);
      rd_op(1, 1, 10'd55, 10'd66);
      rd_op(1, 14, 10'd9, 10'd9);
    end

    // R8: write restarts the count after an odd read
    rd_op(1, 14, 10'd123, 10'd321);
    wr_ctrl(8'h2C);
    rd_op(1, 1, 10'd77, 10'd88);
    rd_op(1, 14, 10'd1, 10'd1);

    // R9: release after an even count drops the pending pair
    cs_release();
    rd_op(1, 1, 10'd44, 10'd45);
    rd_op(1, 14, 10'd1, 10'd1);

    // random pairs with random spacing and source changes
    for (int k = 0; k < 24; k++) begin
      if (k % 8 == 7) wr_ctrl(($urandom % 2) ? 8'h2C : 8'h0C);
      rd_op(1 + int'($urandom % 3), 1, 10'($urandom), 10'($urandom));
      rd_op(1 + int'($urandom % 3), conv_len(ctrl_m) + 1 + int'($urandom % 4),
            10'($urandom), 10'($urandom));
    end

    // R10: release after an odd count sets the sticky flag
    rd_op(1, 3, 10'd12, 10'd13);
    cs_release();
    rd_op(1, 1, 10'd14, 10'd15);
    rd_op(1, 14, 10'd16, 10'd17);
    cs_release();
    chk(seq_err == 1, "R10 flag sticky", seq_err, 1);
    report();
  end
endmodule